// File: doc/BRIEF.md
# MDIO Management Frame Engine

This block is a management master for the two-wire PHY management bus. Software programs a clock divider and then writes a single 32-bit command word. That word already holds the start pattern, the opcode, the PHY and register addresses, the turnaround pattern and the write data. The engine sends a preamble of ones followed by the command word, MSB first, on MDIO. For a read, it releases MDIO for the last eighteen bit times, shifts in the sixteen bits the PHY returns, and places them in the low half of the same command register.

When a frame ends, a sticky completion flag is set. Software clears it by writing a one to that bit. MDC runs at the system clock divided by twice a programmed speed value. A speed of zero stops MDC and keeps the engine idle. Command and speed writes that arrive while a frame is running are dropped.

Top module: `mdio_mgmt_top`

## Requirements
- R1: A write frame places PRE_LEN ones on MDIO, then command bits 31 down to 0 in that order, with MDIO driven for every bit. After the frame, the command register still holds the value that was written.
- R2: Command bits 29:28 equal to 2'b10 select a read. A read frame drives the preamble and command bits 31 down to 18 (start, opcode, PHY address 27:23, register address 22:18), then releases MDIO (output enable low) for the two turnaround bit times and the sixteen data bit times.
- R3: In a read, the engine samples MDIO on sixteen MDC rising edges, MSB first. The first sample is taken on the rising edge that follows the second turnaround bit. The sampled value replaces command bits 15:0, and bits 31:16 stay unchanged.
- R4: The MDC period is 2*S system clocks. S is speed-register bits SPD_W:1, and bit 0 of the speed register is ignored.
- R5: With S equal to zero, MDC stays low, a command write starts no frame, and the completion flag stays clear.
- R6: The completion flag, bit 23 of the event register, is set on the MDC rising edge of the last frame bit. That is the 64th rising edge on which MDIO is driven or released as part of the frame.
- R7: The completion flag stays set until a write to the event register with bit 23 equal to 1. A write with bit 23 equal to 0 leaves the flag set.
- R8: A command write while a frame is in progress is ignored. Neither the running frame nor the register contents change.
- R9: MDIO output and output enable change only when MDC falls (or when MDC is stopped and idle), so they never change while MDC is high.
- R10: After reset, MDC is low, MDIO is released, the completion flag is clear, the command register is zero and the speed is zero.
- R11: A speed write while a frame is in progress is ignored, and MDC keeps its previous period after the frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_we | input | 1 | Command register write strobe; starts a frame when idle and S is non-zero |
| cmd_wdata | input | 32 | Command word to write |
| cmd_rdata | output | 32 | Command register contents, with read data in bits 15:0 after a read |
| spd_we | input | 1 | Speed register write strobe |
| spd_wdata | input | 32 | Speed value; field S in bits SPD_W:1 |
| evt_we | input | 1 | Event register write strobe (write 1 to clear) |
| evt_wdata | input | 32 | Event write data; bit 23 clears the completion flag |
| evt_rdata | output | 32 | Event register; completion flag in bit 23 |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | MDIO output value |
| mdio_oe | output | 1 | MDIO output enable; low releases the line |
| mdio_i | input | 1 | MDIO input value |

## Verification
The bench builds the block with SPD_W=3, so every non-zero speed from 1 to 7 can be swept. At each speed it runs both a write frame and a read frame and checks the MDC period. PRE_LEN keeps its default of 32, which lets the bench check the full frame against {32 ones, command}. At the fastest speed, it sweeps all 32 PHY addresses in write frames and all 32 register addresses in read frames, each with its own data pattern. A responder in the bench returns PHY data on MDC falling edges. Other scenarios cover intrusive command and speed writes during a frame, the stopped-clock case, and both polarities of event writes.

// File: rtl/mdio_mgmt_pkg.sv
`timescale 1ns/1ps
package mdio_mgmt_pkg;

    // Width of the command/data register
    localparam int CMD_W   = 32;
    // Position of the completion flag in the event register
    localparam int EVT_BIT = 23;
    // Opcode field value (bits 29:28) that selects a read
    localparam logic [1:0] OP_READ = 2'b10;

    typedef enum logic [1:0] {
        SQ_IDLE,
        SQ_SHIFT,
        SQ_TAIL
    } sq_state_e;

endpackage

// File: rtl/mdio_clk_div.sv
`timescale 1ns/1ps
module mdio_clk_div #(
    parameter int SPD_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SPD_W-1:0] spd,
    input  logic             restart,
    output logic             mdc,
    output logic             rise_tick,
    output logic             fall_tick
);

    typedef struct packed {
        logic [SPD_W-1:0] cnt;
        logic             mdc;
    } div_t;

    div_t q, d;
    logic run;
    logic tick;

    always_comb begin
        d    = q;
        run  = (spd != '0);
        tick = run && (q.cnt == spd - SPD_W'(1));
        if (!run || restart) begin
            d = '0;
        end else if (tick) begin
            d.cnt = '0;
            d.mdc = ~q.mdc;
        end else begin
            d.cnt = q.cnt + SPD_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign mdc       = q.mdc;
    assign rise_tick = tick && !q.mdc && !restart;
    assign fall_tick = tick &&  q.mdc && !restart;

    // R5: a zero speed forces MDC low on the next edge
    p_mdc_off_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (spd == '0) |=> !q.mdc);

endmodule

// File: rtl/mdio_frame_seq.sv
`timescale 1ns/1ps
module mdio_frame_seq
    import mdio_mgmt_pkg::*;
#(
    parameter int PRE_LEN = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [CMD_W-1:0] cmd,
    input  logic             run,
    input  logic             rise_tick,
    input  logic             fall_tick,
    input  logic             mdio_i,
    output logic             busy,
    output logic             done,
    output logic [15:0]      rdata,
    output logic             mdio_o,
    output logic             mdio_oe
);

    localparam int FRAME_LEN = PRE_LEN + CMD_W;
    localparam int CNT_W     = $clog2(FRAME_LEN + 1);
    // bit index of the first turnaround bit
    localparam logic [CNT_W-1:0] TA_AT   = CNT_W'(PRE_LEN + 14);
    // bits driven so far once the first data bit is on the wire
    localparam logic [CNT_W-1:0] DAT_AT  = CNT_W'(PRE_LEN + 17);
    localparam logic [CNT_W-1:0] LAST_AT = CNT_W'(FRAME_LEN - 1);

    typedef struct packed {
        sq_state_e          state;
        logic [FRAME_LEN-1:0] sh;
        logic [CNT_W-1:0]   cnt;
        logic               is_rd;
        logic [15:0]        rx;
        logic               mdo;
        logic               oe;
    } seq_t;

    seq_t q, d;

    always_comb begin
        d    = q;
        done = 1'b0;
        unique case (q.state)
            SQ_IDLE: begin
                if (fall_tick || !run) d.oe = 1'b0;
                if (start) begin
                    d.sh    = {{PRE_LEN{1'b1}}, cmd};
                    d.cnt   = '0;
                    d.is_rd = (cmd[29:28] == OP_READ);
                    d.rx    = '0;
                    d.state = SQ_SHIFT;
                end
            end
            SQ_SHIFT: begin
                if (fall_tick) begin
                    d.mdo = q.sh[FRAME_LEN-1];
                    d.sh  = q.sh << 1;
                    d.oe  = !(q.is_rd && (q.cnt >= TA_AT));
                    d.cnt = q.cnt + CNT_W'(1);
                    if (q.cnt == LAST_AT) d.state = SQ_TAIL;
                end else if (rise_tick && q.is_rd && (q.cnt >= DAT_AT)) begin
                    d.rx = {q.rx[14:0], mdio_i};
                end
            end
            SQ_TAIL: begin
                if (rise_tick) begin
                    if (q.is_rd) d.rx = {q.rx[14:0], mdio_i};
                    done    = 1'b1;
                    d.state = SQ_IDLE;
                end
            end
            default: d.state = SQ_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q       <= '0;
            q.state <= SQ_IDLE;
            q.mdo   <= 1'b1;
        end else begin
            q <= d;
        end
    end

    assign busy    = (q.state != SQ_IDLE);
    assign rdata   = d.rx;
    assign mdio_o  = q.mdo;
    assign mdio_oe = q.oe;

    // R9: the driven value moves only on a falling MDC tick
    p_mdo_fall_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(q.mdo) |-> $past(fall_tick));

    // R9: the output enable moves only on a falling tick or with MDC stopped
    p_oe_edge_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(q.oe) |-> ($past(fall_tick) || $past(!run)));

    // R2: once turnaround of a read has begun, MDIO stays released
    p_ta_release_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (q.state == SQ_SHIFT && q.is_rd && q.cnt > TA_AT) |-> !q.oe);

endmodule

// File: rtl/mdio_mgmt_top.sv
`timescale 1ns/1ps
module mdio_mgmt_top
    import mdio_mgmt_pkg::*;
#(
    parameter int SPD_W   = 6,
    parameter int PRE_LEN = 32
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cmd_we,
    input  logic [31:0] cmd_wdata,
    output logic [31:0] cmd_rdata,
    input  logic        spd_we,
    input  logic [31:0] spd_wdata,
    input  logic        evt_we,
    input  logic [31:0] evt_wdata,
    output logic [31:0] evt_rdata,
    output logic        mdc,
    output logic        mdio_o,
    output logic        mdio_oe,
    input  logic        mdio_i
);

    typedef struct packed {
        logic [CMD_W-1:0] cmd;
        logic [SPD_W-1:0] spd;
        logic             evt;
    } regs_t;

    regs_t q, d;

    logic        busy, done, start, spd_acc, rise_tick, fall_tick, run;
    logic [15:0] rdata;
    logic        unused_bits;

    assign unused_bits = ^{spd_wdata[31:SPD_W+1], spd_wdata[0],
                           evt_wdata[31:EVT_BIT+1], evt_wdata[EVT_BIT-1:0]};

    always_comb begin
        d       = q;
        run     = (q.spd != '0);
        start   = cmd_we && !busy && run;
        spd_acc = spd_we && !busy;
        if (cmd_we && !busy) d.cmd = cmd_wdata;
        if (done && (q.cmd[29:28] == OP_READ)) d.cmd[15:0] = rdata;
        if (spd_acc) d.spd = spd_wdata[SPD_W:1];
        if (evt_we && evt_wdata[EVT_BIT]) d.evt = 1'b0;
        if (done) d.evt = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    mdio_clk_div #(.SPD_W(SPD_W)) i_div (
        .clk       (clk),
        .rst_n     (rst_n),
        .spd       (q.spd),
        .restart   (spd_acc),
        .mdc       (mdc),
        .rise_tick (rise_tick),
        .fall_tick (fall_tick)
    );

    mdio_frame_seq #(.PRE_LEN(PRE_LEN)) i_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .cmd       (cmd_wdata),
        .run       (run),
        .rise_tick (rise_tick),
        .fall_tick (fall_tick),
        .mdio_i    (mdio_i),
        .busy      (busy),
        .done      (done),
        .rdata     (rdata),
        .mdio_o    (mdio_o),
        .mdio_oe   (mdio_oe)
    );

    assign cmd_rdata = q.cmd;
    assign evt_rdata = {{(31-EVT_BIT){1'b0}}, q.evt, {EVT_BIT{1'b0}}};

    // R6: the flag rises only as a frame completes
    p_evt_on_done_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(q.evt) |-> $past(done));

    // R8: the command register is frozen while a frame runs
    p_cmd_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done) |=> $stable(q.cmd));

    // R11: the speed is frozen while a frame runs
    p_spd_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(q.spd));

    // R5: a stopped clock never lets a frame begin
    p_no_start_off_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (q.spd == '0 && !busy) |=> !busy);

endmodule

// File: tb/test_mdio_mgmt_top.sv
`timescale 1ns/1ps
module test_mdio_mgmt_top;

    localparam int SPD_W = 3;
    localparam int PRE   = 32;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_we = 1'b0, spd_we = 1'b0, evt_we = 1'b0;
    logic [31:0] cmd_wdata = '0, spd_wdata = '0, evt_wdata = '0;
    logic [31:0] cmd_rdata, evt_rdata;
    logic        mdc, mdio_o, mdio_oe;
    logic        mdio_i = 1'b1;

    always #2.5 clk = ~clk;

    mdio_mgmt_top #(.SPD_W(SPD_W), .PRE_LEN(PRE)) i_mdio_mgmt_top (
        .clk(clk), .rst_n(rst_n),
        .cmd_we(cmd_we), .cmd_wdata(cmd_wdata), .cmd_rdata(cmd_rdata),
        .spd_we(spd_we), .spd_wdata(spd_wdata),
        .evt_we(evt_we), .evt_wdata(evt_wdata), .evt_rdata(evt_rdata),
        .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
    );

    int total = 0;
    int bad   = 0;

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // PHY responder: drives read data after falling MDC edges
    logic        resp_on = 1'b0;
    logic        seen_drive = 1'b0;
    int          z = 0;
    logic [15:0] phy_data = '0;

    always @(posedge mdc) begin
        if (resp_on) begin
            if (mdio_oe) seen_drive = 1'b1;
            else if (seen_drive) z = z + 1;
        end
    end

    always @(negedge mdc) begin
        if (resp_on && z >= 2 && z < 18) mdio_i = phy_data[17 - z];
    end

    // R9 monitor: no change of MDIO while MDC is high
    int   r9_viol = 0;
    logic last_mdc = 1'b0, last_o = 1'b1, last_oe = 1'b0;
    always @(negedge clk) begin
        if (rst_n && mdc && last_mdc && (mdio_o !== last_o || mdio_oe !== last_oe))
            r9_viol++;
        last_mdc = mdc; last_o = mdio_o; last_oe = mdio_oe;
    end

    task automatic wr_cmd(input logic [31:0] v);
        @(negedge clk); cmd_we = 1'b1; cmd_wdata = v;
        @(negedge clk); cmd_we = 1'b0;
    endtask

    task automatic wr_spd(input logic [31:0] v);
        @(negedge clk); spd_we = 1'b1; spd_wdata = v;
        @(negedge clk); spd_we = 1'b0;
    endtask

    task automatic wr_evt(input logic [31:0] v);
        @(negedge clk); evt_we = 1'b1; evt_wdata = v;
        @(negedge clk); evt_we = 1'b0;
    endtask

    task automatic set_speed(input int s);
        wr_spd((32'(s) << 1) | 32'h1); // bit 0 set: must be ignored (R4)
        repeat (20) @(negedge clk);
    endtask

    task automatic run_frame(input logic [4:0] phy, input logic [4:0] rg, input bit is_rd,
                             input logic [15:0] wdat, input logic [15:0] pval, input int spd,
                             input bit intrude);
        logic [31:0] cmd;
        logic [63:0] got, gotoe, exp;
        int          nrec;
        int          guard;
        bit          started;
        realtime     t0, t1;
        cmd = {2'b01, (is_rd ? 2'b10 : 2'b01), phy, rg, 2'b10, (is_rd ? 16'h0 : wdat)};
        exp = {32'hFFFF_FFFF, cmd};
        got = '0; gotoe = '0; nrec = 0; guard = 0; started = 0; t0 = 0; t1 = 0;
        phy_data = pval; z = 0; seen_drive = 1'b0; resp_on = is_rd;
        wr_cmd(cmd);
        if (intrude) begin
            fork
                begin
                    repeat (40) @(posedge clk);
                    wr_cmd(32'h5A5A_1234);
                    wr_spd(32'(2) << 1);
                end
            join_none
        end
        while (guard < 200) begin
            @(posedge mdc); #1;
            guard++;
            if (!started && mdio_oe) started = 1;
            if (started) begin
                if (nrec < 64) begin
                    got[63 - nrec]   = mdio_o;
                    gotoe[63 - nrec] = mdio_oe;
                end
                if (nrec == 0) t0 = $realtime;
                if (nrec == 1) t1 = $realtime;
                nrec++;
            end
            if (evt_rdata[23]) break;
        end
        resp_on = 1'b0;
        chk(nrec == 64, "R6 flag on last rising edge", 64'(nrec), 64'd64);
        if (!is_rd) begin
            chk(got == exp && gotoe == '1, intrude ? "R8 frame bits" : "R1 frame bits", got, exp);
            chk(cmd_rdata == cmd, intrude ? "R8 register" : "R1 register", 64'(cmd_rdata), 64'(cmd));
        end else begin
            chk(got[63:18] == exp[63:18] && gotoe == {{46{1'b1}}, 18'h0},
                "R2 read frame and release", {got[63:18], 18'h0} | 64'(gotoe[17:0]), {exp[63:18], 18'h0});
            chk(cmd_rdata == {cmd[31:16], pval}, "R3 read data", 64'(cmd_rdata), 64'({cmd[31:16], pval}));
        end
        chk(int'((t1 - t0) / 5.0) == 2 * spd, "R4 MDC period", 64'(int'((t1 - t0) / 5.0)), 64'(2 * spd));
        chk(evt_rdata == 32'h0080_0000, "R6 flag set", 64'(evt_rdata), 64'h0080_0000);
        wr_evt(32'hFF7F_FFFF);
        chk(evt_rdata == 32'h0080_0000, "R7 zero write keeps flag", 64'(evt_rdata), 64'h0080_0000);
        wr_evt(32'h0080_0000);
        chk(evt_rdata == 32'h0, "R7 one write clears flag", 64'(evt_rdata), 64'h0);
        repeat (20) @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int highs;
        realtime ta, tb;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R10 reset state
        chk(mdc == 0 && mdio_oe == 0, "R10 MDC low and MDIO released", {62'h0, mdc, mdio_oe}, 64'h0);
        chk(evt_rdata == 0 && cmd_rdata == 0, "R10 registers clear", {evt_rdata, cmd_rdata}, 64'h0);

        // R5: stopped clock
        highs = 0;
        wr_cmd(32'h5082_0000 | 32'h1234);
        for (int i = 0; i < 300; i++) begin
            @(negedge clk);
            if (mdc) highs++;
        end
        chk(highs == 0, "R5 MDC stays low", 64'(highs), 64'h0);
        chk(evt_rdata == 0 && mdio_oe == 0, "R5 no frame started", {evt_rdata, 31'h0, mdio_oe}, 64'h0);

        // speed sweep: one write and one read at each speed
        for (int s = 1; s < 8; s++) begin
            set_speed(s);
            run_frame(5'(s * 3), 5'(31 - s), 1'b0, 16'(16'hC35A ^ (s * 16'h0111)), 16'h0, s, 1'b0);
            run_frame(5'(s + 9), 5'(s * 4), 1'b1, 16'h0, 16'(16'h9E17 ^ (s * 16'h1301)), s, 1'b0);
        end

        // address sweep at the fastest speed
        set_speed(1);
        for (int a = 0; a < 32; a++) begin
            run_frame(5'(a), 5'(31 - a), 1'b0, 16'((a * 16'h0801) ^ 16'hA5C3), 16'h0, 1, 1'b0);
            run_frame(5'(31 - a), 5'(a), 1'b1, 16'h0, 16'((a * 16'h1041) ^ 16'h6B2D), 1, 1'b0);
        end

        // R8 / R11: writes during a frame are dropped
        set_speed(3);
        run_frame(5'd17, 5'd6, 1'b0, 16'hBEEF, 16'h0, 3, 1'b1);
        @(posedge mdc); ta = $realtime;
        @(posedge mdc); tb = $realtime;
        chk(int'((tb - ta) / 5.0) == 6, "R11 speed kept", 64'(int'((tb - ta) / 5.0)), 64'd6);

        chk(r9_viol == 0, "R9 MDIO stable while MDC high", 64'(r9_viol), 64'h0);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule